// File: doc/BRIEF.md
# Phase/Frequency Comparator with Lock Qualification

This block sits between the two programmable dividers of a frequency synthesizer and the charge pump. It takes one-cycle pulses marking each divided reference edge (`fr_pulse`) and each divided feedback edge (`fp_pulse`), all sampled on the reference-oscillator clock. It keeps an up/down flip-flop pair, turns that pair into pump controls and two outputs for an external pump, and measures each phase error in oscillator cycles to keep a lock flag. A polarity bit swaps the pump sense, so the same loop can work with either slope of the oscillator's tuning curve.

A shared status pin carries either the lock flag or a live copy of one divided input, picked by a select bit. The polarity bit decides which input is copied. A power-down input quiets the pump and resets the detector and the lock logic, and it holds the reported lock flag high for as long as it is asserted. A separate active-low input takes the pump's drive enable away without touching the detector.

Top module: `phase_lock_cmp`

## Requirements
- R1: Once reset is released, with no input pulses, `cp_up`, `cp_dn`, `cp_oe`, `ext_r` and `ext_p_pull` are all 0, and `ld_mon` is 0 while `mon_sel` is 0.
- R2: With `pol_fc`=1, suppose `fr_pulse` comes d>0 cycles ahead of `fp_pulse`. Then `cp_up` is high for d+1 cycles, starting in the cycle after `fr_pulse` is sampled, and `cp_dn` is high for 1 cycle. If `fp_pulse` leads instead, the two counts are exchanged.
- R3: With `pol_fc`=0, `cp_up` and `cp_dn` swap roles relative to R2.
- R4: When both pulses arrive in the same cycle, `cp_up` and `cp_dn` are both high for exactly one cycle. This is the minimum correction pulse that keeps the loop out of a dead zone.
- R5: If a second pulse arrives on the leading input before the lagging pulse, the leading control stays high and the other control stays low. This gives frequency detection over a full ±2π range.
- R6: `ext_p_pull` (1 = pull the open-drain line low) follows `cp_up`. `ext_r` follows `cp_dn`.
- R7: `cp_oe` is 1 exactly when `cp_up` or `cp_dn` is 1, `zc_n` is 1 and `pwr_on` is 1. When `zc_n` is 0, `cp_oe` is 0 and `ext_r`/`ext_p_pull` still track the detector.
- R8: The lock flag goes low on the clock edge that completes the UNLOCK_CYC-th cycle (default 8) of a one-sided phase error.
- R9: A comparison counts as good when its error d is below UNLOCK_CYC and no greater than LOCK_CYC (default 16). The lock flag goes high at the end of the QUAL_CMP-th (default 3) consecutive good comparison. A comparison that is not good clears the count.
- R10: When `mon_sel` is 1, `ld_mon` equals `fr_pulse` if `pol_fc` is 1 and `fp_pulse` if `pol_fc` is 0. When `mon_sel` is 0, `ld_mon` shows the lock flag.
- R11: While `pwr_on` is 0:
  - all pump and external outputs are 0;
  - `ld_mon` is 1 when `mon_sel` is 0;
  - input pulses are ignored.
  
  After `pwr_on` returns to 1, the detector is idle, the lock flag is 0 and the good-comparison count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fr_pulse | input | 1 | One-cycle pulse per divided reference edge |
| fp_pulse | input | 1 | One-cycle pulse per divided feedback edge |
| pol_fc | input | 1 | Pump polarity: 1 = normal, 0 = swapped |
| mon_sel | input | 1 | Status select: 1 = divided input copy, 0 = lock flag |
| pwr_on | input | 1 | 1 = normal, 0 = power save |
| zc_n | input | 1 | 0 forces the pump drive off |
| cp_up | output | 1 | Pump control driving the output high |
| cp_dn | output | 1 | Pump control driving the output low |
| cp_oe | output | 1 | Pump drive enable (0 = high impedance) |
| ext_r | output | 1 | External-pump push-pull phase output |
| ext_p_pull | output | 1 | External-pump open-drain output, 1 = pull low |
| ld_mon | output | 1 | Shared lock flag / monitor output |

## Verification
The assertions assume that a pulse on one input is never followed by a pulse on the same input in the very next cycle. They also assume that the two inputs never pulse together in the cycle in which the detector clears. Real divider outputs are many cycles apart, so this holds in practice. The stimulus drives each pulse for exactly one cycle, sets inputs on the falling edge, and leaves several idle cycles after every comparison before the next one starts.

// File: rtl/phase_lock_pkg.sv
// Shared helpers for the phase comparator: a width helper used to size
// the error counter from the two lock thresholds.
package phase_lock_pkg;

    // Larger of two unsigned values, for deriving counter limits.
    function automatic int unsigned pl_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/phase_lock_pfd.sv
// Up/down flip-flop pair of the phase/frequency detector.
// Assumes fr_pulse/fp_pulse are single-cycle, synchronous to clk.
// When both flops are set they clear together on the next edge, which
// yields a one-cycle pulse on both sides when the inputs coincide.
module phase_lock_pfd (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fr_pulse,
    input  logic fp_pulse,
    output logic up_q,
    output logic dn_q
);

    // Set on arriving edges, clear both once both are set; idle in power save.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (up_q && dn_q) begin
            up_q <= fr_pulse;
            dn_q <= fp_pulse;
        end else begin
            up_q <= up_q | fr_pulse;
            dn_q <= dn_q | fp_pulse;
        end
    end

endmodule

// File: rtl/phase_lock_qual.sv
// Lock qualifier: counts one-sided error cycles per comparison, drops
// the lock flag once the count reaches UNLOCK_CYC and raises it after
// QUAL_CMP consecutive good comparisons. Assumes up_q/dn_q come from
// phase_lock_pfd (both high marks the end of a comparison).
module phase_lock_qual
    import phase_lock_pkg::*;
#(
    parameter int unsigned UNLOCK_CYC = 8,
    parameter int unsigned LOCK_CYC   = 16,
    parameter int unsigned QUAL_CMP   = 3,
    localparam int unsigned CNT_MAX   = pl_max(UNLOCK_CYC, LOCK_CYC) + 1,
    localparam int unsigned CW        = $clog2(CNT_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          up_q,
    input  logic          dn_q,
    output logic          lock_q,
    output logic [CW-1:0] err_cnt
);

    localparam int unsigned QW = $clog2(QUAL_CMP + 1);

    logic          one_side;
    logic          cmp_end;
    logic          trip;
    logic          good;
    logic [QW-1:0] qual_cnt;

    // Classify the current detector state and the finished comparison.
    always_comb begin
        one_side = up_q ^ dn_q;
        cmp_end  = up_q & dn_q;
        trip     = one_side && (err_cnt == CW'(UNLOCK_CYC - 1));
        good     = (err_cnt < CW'(UNLOCK_CYC)) && (err_cnt <= CW'(LOCK_CYC));
    end

    // Saturating width of the one-sided error within the current comparison.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || cmp_end) begin
            err_cnt <= '0;
        end else if (one_side && (err_cnt != CW'(CNT_MAX))) begin
            err_cnt <= err_cnt + 1'b1;
        end
    end

    // Lock flag and consecutive-good-comparison counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            qual_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (trip) begin
            qual_cnt <= '0;
            lock_q   <= 1'b0;
        end else if (cmp_end) begin
            if (!good) begin
                qual_cnt <= '0;
                lock_q   <= 1'b0;
            end else if (qual_cnt >= QW'(QUAL_CMP - 1)) begin
                qual_cnt <= QW'(QUAL_CMP);
                lock_q   <= 1'b1;
            end else begin
                qual_cnt <= qual_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/phase_lock_steer.sv
// Output steering: applies polarity to the detector pair, gates the pump
// enable with power save and the forced-off input, and selects the
// shared status output. Purely combinational.
module phase_lock_steer (
    input  logic pol_fc,
    input  logic run,
    input  logic zc_n,
    input  logic mon_sel,
    input  logic fr_pulse,
    input  logic fp_pulse,
    input  logic up_q,
    input  logic dn_q,
    input  logic lock_q,
    output logic cp_up,
    output logic cp_dn,
    output logic cp_oe,
    output logic ext_r,
    output logic ext_p_pull,
    output logic ld_mon
);

    logic hi_side;
    logic lo_side;
    logic lock_out;
    logic mon_copy;

    // Map detector state to pump sides and build the status output.
    always_comb begin
        hi_side    = run & (pol_fc ? up_q : dn_q);
        lo_side    = run & (pol_fc ? dn_q : up_q);
        cp_up      = hi_side;
        cp_dn      = lo_side;
        cp_oe      = (hi_side | lo_side) & zc_n & run;
        ext_p_pull = hi_side;
        ext_r      = lo_side;
        lock_out   = run ? lock_q : 1'b1;
        mon_copy   = pol_fc ? fr_pulse : fp_pulse;
        ld_mon     = mon_sel ? mon_copy : lock_out;
    end

endmodule

// File: rtl/phase_lock_cmp.sv
// Top of the phase comparator with lock detector. Clocked by the
// reference oscillator; divided edges arrive as one-cycle pulses.
// pwr_on low resets detector and lock logic and forces the locked-state
// outputs.
module phase_lock_cmp #(
    parameter int unsigned UNLOCK_CYC = 8,
    parameter int unsigned LOCK_CYC   = 16,
    parameter int unsigned QUAL_CMP   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fr_pulse,
    input  logic fp_pulse,
    input  logic pol_fc,
    input  logic mon_sel,
    input  logic pwr_on,
    input  logic zc_n,
    output logic cp_up,
    output logic cp_dn,
    output logic cp_oe,
    output logic ext_r,
    output logic ext_p_pull,
    output logic ld_mon
);

    localparam int unsigned CW =
        $clog2(phase_lock_pkg::pl_max(UNLOCK_CYC, LOCK_CYC) + 2);

    logic          pd_up;
    logic          pd_dn;
    logic          lock_q;
    logic [CW-1:0] err_cnt;

    phase_lock_pfd u_pfd (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pwr_on),
        .fr_pulse (fr_pulse),
        .fp_pulse (fp_pulse),
        .up_q     (pd_up),
        .dn_q     (pd_dn)
    );

    phase_lock_qual #(
        .UNLOCK_CYC (UNLOCK_CYC),
        .LOCK_CYC   (LOCK_CYC),
        .QUAL_CMP   (QUAL_CMP)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (pwr_on),
        .up_q    (pd_up),
        .dn_q    (pd_dn),
        .lock_q  (lock_q),
        .err_cnt (err_cnt)
    );

    phase_lock_steer u_steer (
        .pol_fc     (pol_fc),
        .run        (pwr_on),
        .zc_n       (zc_n),
        .mon_sel    (mon_sel),
        .fr_pulse   (fr_pulse),
        .fp_pulse   (fp_pulse),
        .up_q       (pd_up),
        .dn_q       (pd_dn),
        .lock_q     (lock_q),
        .cp_up      (cp_up),
        .cp_dn      (cp_dn),
        .cp_oe      (cp_oe),
        .ext_r      (ext_r),
        .ext_p_pull (ext_p_pull),
        .ld_mon     (ld_mon)
    );

endmodule

// File: rtl/phase_lock_cmp_chk.sv
// Property checker for phase_lock_cmp, attached with bind. Assumes the
// input pulses never repeat on the same input in back-to-back cycles.
module phase_lock_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic fr_pulse,
    input logic fp_pulse,
    input logic pol_fc,
    input logic mon_sel,
    input logic pwr_on,
    input logic zc_n,
    input logic cp_up,
    input logic cp_dn,
    input logic cp_oe,
    input logic ext_r,
    input logic ext_p_pull,
    input logic ld_mon,
    input logic pd_up,
    input logic pd_dn,
    input logic lock_q
);

    p_pol_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && pol_fc && pd_up && !pd_dn) |-> (cp_up && !cp_dn && ext_p_pull && !ext_r));

    p_pol_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !pol_fc && pd_up && !pd_dn) |-> (cp_dn && !cp_up && ext_r && !ext_p_pull));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && pd_up && pd_dn && !fr_pulse && !fp_pulse) |=> (!pd_up && !pd_dn));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && pd_up && !pd_dn && !fp_pulse) |=> pd_up);

    p_zc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !zc_n |-> !cp_oe);

    p_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_q) |-> ($past(pd_up != pd_dn) || !$past(pwr_on) || $past(pd_up && pd_dn)));

    p_lock_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(pd_up && pd_dn));

    p_mon_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_on && !mon_sel) |-> (ld_mon == lock_q));

    p_mon_fr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_sel && pol_fc) |-> (ld_mon == fr_pulse));

    p_ps_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (!cp_oe && !cp_up && !cp_dn && !ext_r && !ext_p_pull));

    p_ps_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_on && !mon_sel) |-> ld_mon);

endmodule

bind phase_lock_cmp phase_lock_cmp_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fr_pulse   (fr_pulse),
    .fp_pulse   (fp_pulse),
    .pol_fc     (pol_fc),
    .mon_sel    (mon_sel),
    .pwr_on     (pwr_on),
    .zc_n       (zc_n),
    .cp_up      (cp_up),
    .cp_dn      (cp_dn),
    .cp_oe      (cp_oe),
    .ext_r      (ext_r),
    .ext_p_pull (ext_p_pull),
    .ld_mon     (ld_mon),
    .pd_up      (pd_up),
    .pd_dn      (pd_dn),
    .lock_q     (lock_q)
);

// File: tb/sim_phase_lock_cmp.sv
// Bench for phase_lock_cmp: a table of comparisons walked by one loop,
// then directed tests for reset, unlock timing, frequency detection,
// forced-off pump, monitor select and power save.
module sim_phase_lock_cmp;

    localparam int UNLOCK = 8;
    localparam int LOCKT  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fr_pulse = 1'b0;
    logic fp_pulse = 1'b0;
    logic pol_fc = 1'b1;
    logic mon_sel = 1'b0;
    logic pwr_on = 1'b1;
    logic zc_n = 1'b1;
    logic cp_up, cp_dn, cp_oe, ext_r, ext_p_pull, ld_mon;

    int nchk = 0;
    int nerr = 0;
    int mq = 0;
    int mlock = 0;
    int cu, cd, coe, cr, cpp;
    bit done = 1'b0;

    // Entry: {pol, lead (0 = fr first, 1 = fp first), 6-bit gap}
    localparam logic [7:0] VEC [0:11] = '{
        {1'b1, 1'b0, 6'd3},  {1'b1, 1'b1, 6'd2},  {1'b0, 1'b0, 6'd4},
        {1'b0, 1'b1, 6'd0},  {1'b1, 1'b0, 6'd10}, {1'b1, 1'b0, 6'd7},
        {1'b0, 1'b1, 6'd8},  {1'b1, 1'b1, 6'd5},  {1'b1, 1'b0, 6'd0},
        {1'b0, 1'b0, 6'd6},  {1'b1, 1'b1, 6'd12}, {1'b1, 1'b0, 6'd1}
    };

    phase_lock_cmp u0 (
        .clk(clk), .rst_n(rst_n), .fr_pulse(fr_pulse), .fp_pulse(fp_pulse),
        .pol_fc(pol_fc), .mon_sel(mon_sel), .pwr_on(pwr_on), .zc_n(zc_n),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_oe(cp_oe), .ext_r(ext_r),
        .ext_p_pull(ext_p_pull), .ld_mon(ld_mon)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Lock model from R8/R9 for one finished comparison with error d.
    task automatic model_cmp(input int d);
        if (d < UNLOCK && d <= LOCKT) begin
            if (mq >= 2) begin mq = 3; mlock = 1; end
            else mq++;
        end else begin
            mq = 0; mlock = 0;
        end
    endtask

    // One comparison: leader pulses at cycle 0, follower at cycle d.
    task automatic run_cmp(input int lead, input int d);
        cu = 0; cd = 0; coe = 0; cr = 0; cpp = 0;
        for (int c = 0; c < d + 6; c++) begin
            @(negedge clk);
            fr_pulse = (lead == 0 && c == 0) || (lead == 1 && c == d);
            fp_pulse = (lead == 1 && c == 0) || (lead == 0 && c == d);
            @(posedge clk); #1;
            cu += int'(cp_up); cd += int'(cp_dn); coe += int'(cp_oe);
            cr += int'(ext_r); cpp += int'(ext_p_pull);
        end
        @(negedge clk);
        fr_pulse = 1'b0; fp_pulse = 1'b0;
        model_cmp(d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            fr_pulse = 1'b0; fp_pulse = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 cp_up", cp_up, 0);
        chk("R1 cp_dn", cp_dn, 0);
        chk("R1 cp_oe", cp_oe, 0);
        chk("R1 ext", ext_r | ext_p_pull, 0);
        chk("R1 lock", ld_mon, 0);

        // Table walk: R2, R3, R4, R6, R7, R8, R9
        foreach (VEC[i]) begin
            int d, lead, upc, dnc, hi, lo;
            d = int'(VEC[i][5:0]);
            lead = int'(VEC[i][6]);
            @(negedge clk);
            pol_fc = VEC[i][7];
            upc = (lead == 0) ? d + 1 : 1;
            dnc = (lead == 1) ? d + 1 : 1;
            hi = pol_fc ? upc : dnc;
            lo = pol_fc ? dnc : upc;
            run_cmp(lead, d);
            chk(pol_fc ? "R2 cp_up width" : "R3 cp_up width", cu, hi);
            chk(pol_fc ? "R2 cp_dn width" : "R3 cp_dn width", cd, lo);
            if (d == 0) chk("R4 coincident pulse", cu + cd, 2);
            chk("R6 ext_p_pull width", cpp, hi);
            chk("R6 ext_r width", cr, lo);
            chk("R7 cp_oe width", coe, (d == 0) ? 1 : d + 1);
            chk("R9 R8 lock after comparison", ld_mon, mlock);
        end

        // R8: unlock edge timing from a locked state
        @(negedge clk); pol_fc = 1'b1;
        for (int k = 0; k < 3; k++) run_cmp(0, 1);
        chk("R9 relock", ld_mon, 1);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            fr_pulse = (k == 0);
            @(posedge clk); #1;
            if (k >= 1) chk("R8 unlock timing", ld_mon, (k < UNLOCK) ? 1 : 0);
        end
        @(negedge clk); fp_pulse = 1'b1;
        idle(4);
        mq = 0; mlock = 0;

        // R5: repeated leading pulse keeps one side active
        @(negedge clk); fr_pulse = 1'b1;
        idle(3);
        @(negedge clk); fr_pulse = 1'b1;
        @(posedge clk); #1;
        chk("R5 up held", cp_up, 1);
        chk("R5 dn quiet", cp_dn, 0);
        idle(2);
        chk("R5 up still held", cp_up, 1);
        @(negedge clk); fp_pulse = 1'b1;
        idle(4);
        chk("R5 cleared", cp_up | cp_dn, 0);

        // R7: forced-off drive enable leaves detector outputs alive
        @(negedge clk); zc_n = 1'b0; fr_pulse = 1'b1;
        @(posedge clk); #1;
        chk("R7 oe forced off", cp_oe, 0);
        chk("R7 cp_up alive", cp_up, 1);
        chk("R7 ext_p_pull alive", ext_p_pull, 1);
        @(negedge clk); fr_pulse = 1'b0; fp_pulse = 1'b1;
        idle(4);
        @(negedge clk); zc_n = 1'b1;

        // R11: lock up, then power save in the middle of an error
        for (int k = 0; k < 3; k++) run_cmp(1, 2);
        chk("R9 lock before save", ld_mon, 1);
        @(negedge clk); fr_pulse = 1'b1;
        idle(2);
        chk("R11 error active", cp_up, 1);
        @(negedge clk); pwr_on = 1'b0; #1;
        chk("R11 pump quiet", cp_up | cp_dn | cp_oe | ext_r | ext_p_pull, 0);
        chk("R11 lock forced", ld_mon, 1);

        // R10: monitor copies during power save (detector ignores pulses)
        mon_sel = 1'b1; pol_fc = 1'b1; fr_pulse = 1'b1; #1;
        chk("R10 fr copy high", ld_mon, 1);
        @(negedge clk); fr_pulse = 1'b0; fp_pulse = 1'b1; #1;
        chk("R10 fr copy low", ld_mon, 0);
        @(negedge clk); pol_fc = 1'b0; #1;
        chk("R10 fp copy high", ld_mon, 1);
        @(negedge clk); fp_pulse = 1'b0; fr_pulse = 1'b1; #1;
        chk("R10 fp copy low", ld_mon, 0);
        @(negedge clk); fr_pulse = 1'b0; mon_sel = 1'b0; #1;
        chk("R11 lock forced again", ld_mon, 1);

        // R11: wake up with detector and qualification cleared
        @(negedge clk); pwr_on = 1'b1; pol_fc = 1'b1;
        @(posedge clk); #1;
        chk("R11 wake pump idle", cp_up | cp_dn | cp_oe, 0);
        chk("R11 wake lock low", ld_mon, 0);
        mq = 0; mlock = 0;
        for (int k = 0; k < 2; k++) run_cmp(0, 1);
        chk("R11 count restarted", ld_mon, 0);
        run_cmp(0, 1);
        chk("R9 third good comparison", ld_mon, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule